// File: doc/BRIEF.md
# AXI Write Lane Splitter

This block sits between one 256-bit AXI write master and two 128-bit AXI write slaves. The wide data path is divided by byte lane, not serialised. The lower slave stores the low half of every wide beat and the upper slave stores the high half. Each slave still sees a legal incrementing burst that covers the bytes it actually receives.

Each upstream beat covers 32 bytes. The block forwards it to each slave as two 16-byte beats. The first of the pair carries that slave's half of the data and strobes. The second has all strobes cleared, because that 16-byte slot was written through the other slave. Both downstream bursts are therefore twice the upstream length, with a 16-byte size. The upper slave's start address is offset by 16 bytes. The two write responses are combined into one response for the master.

Only one write transaction is in flight at a time. The master must issue INCR bursts of 32-byte beats. The start address must be 32-byte aligned and the burst must be at most 128 beats long.

Top module: `axi_wr_lane_split`

## Requirements
- R1: Upstream data bits [127:0] with strobe bits [15:0] reach the lower slave, and data bits [255:128] with strobe bits [31:16] reach the upper slave.
- R2: The lower slave's start address equals the upstream start address; the upper slave's start address is the upstream start address plus 16.
- R3: Each downstream address request carries length 2*L+1, where L is the upstream length field, size code 4 (16 bytes) and burst code 2'b01 (INCR). Each slave then receives exactly 2*(L+1) data beats.
- R4: On each downstream burst, beat 2k carries that slave's strobe half of upstream beat k and beat 2k+1 has an all-zero strobe.
- R5: A downstream last flag is raised only on beat 2*(L+1)-1 of that burst.
- R6: The upstream write channel accepts beat k only after both slaves have accepted all 2k downstream beats of the earlier upstream beats. A downstream data beat that is stalled keeps its valid, strobe and last flag unchanged.
- R7: The two downstream address channels complete their handshakes independently, and each one holds its valid and address until accepted.
- R8: While a transaction is open, from address acceptance until its response handshake, the upstream address ready stays low.
- R9: The upstream response is raised only after both slave responses have arrived. Its code is the numerically larger of the two (DECERR 3 over SLVERR 2 over EXOKAY 1 over OKAY 0). It is held unchanged until accepted, and it drops after the handshake.
- R10: The bytes stored by the two slaves at their burst addresses match exactly the bytes the master wrote, with enabled strobes, at its own burst addresses.
- R11: After reset the upstream address and data ready signals are high, and no downstream valid or upstream response valid is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| s_awaddr | input | 32 | Upstream write start address |
| s_awlen | input | 8 | Upstream burst length minus one |
| s_awsize | input | 3 | Upstream transfer size code (must be 5) |
| s_awburst | input | 2 | Upstream burst type (must be INCR) |
| s_awvalid | input | 1 | Upstream address valid |
| s_awready | output | 1 | Upstream address ready |
| s_wdata | input | 256 | Upstream write data |
| s_wstrb | input | 32 | Upstream byte strobes |
| s_wlast | input | 1 | Upstream last beat |
| s_wvalid | input | 1 | Upstream data valid |
| s_wready | output | 1 | Upstream data ready |
| s_bresp | output | 2 | Combined write response |
| s_bvalid | output | 1 | Combined response valid |
| s_bready | input | 1 | Upstream response ready |
| lo_awaddr | output | 32 | Lower slave start address |
| lo_awlen | output | 8 | Lower slave burst length minus one |
| lo_awsize | output | 3 | Lower slave size code |
| lo_awburst | output | 2 | Lower slave burst type |
| lo_awvalid | output | 1 | Lower slave address valid |
| lo_awready | input | 1 | Lower slave address ready |
| lo_wdata | output | 128 | Lower slave write data |
| lo_wstrb | output | 16 | Lower slave byte strobes |
| lo_wlast | output | 1 | Lower slave last beat |
| lo_wvalid | output | 1 | Lower slave data valid |
| lo_wready | input | 1 | Lower slave data ready |
| lo_bresp | input | 2 | Lower slave response code |
| lo_bvalid | input | 1 | Lower slave response valid |
| lo_bready | output | 1 | Lower slave response ready |
| hi_awaddr | output | 32 | Upper slave start address |
| hi_awlen | output | 8 | Upper slave burst length minus one |
| hi_awsize | output | 3 | Upper slave size code |
| hi_awburst | output | 2 | Upper slave burst type |
| hi_awvalid | output | 1 | Upper slave address valid |
| hi_awready | input | 1 | Upper slave address ready |
| hi_wdata | output | 128 | Upper slave write data |
| hi_wstrb | output | 16 | Upper slave byte strobes |
| hi_wlast | output | 1 | Upper slave last beat |
| hi_wvalid | output | 1 | Upper slave data valid |
| hi_wready | input | 1 | Upper slave data ready |
| hi_bresp | input | 2 | Upper slave response code |
| hi_bvalid | input | 1 | Upper slave response valid |
| hi_bready | output | 1 | Upper slave response ready |

## Verification
The splitter is tried with four kinds of burst:
- A four-beat burst at address zero with every strobe set, which checks the exact per-slave address layout of interleaved 16-byte slots.
- A single-beat burst, where the data beat and the null beat are also the first and last beats.
- A sixteen-beat burst at a non-zero aligned address, with slaves that stall on different rhythms. This separates correct hold-and-drain sequencing from designs that lose or repeat beats.
- A long burst with mixed strobes.

The strobe patterns include beats where one half is entirely disabled, so that a null beat and a data beat with an empty strobe are both seen. The response pairs cover each error code against OKAY and the two error codes against each other, which tells a true maximum apart from a fixed pick of one side.

// File: rtl/axi_lsplit_pkg.sv
// Shared constants, types and helpers for the AXI write lane splitter.
// Assumes the AXI response encoding where a larger code is more severe.
package axi_lsplit_pkg;

    localparam logic [1:0] BURST_INCR = 2'b01;

    // Progress of one downstream side through the two beats of a held wide beat
    typedef enum logic [1:0] {
        PH_DATA = 2'd0,
        PH_NULL = 2'd1,
        PH_DONE = 2'd2
    } beat_phase_e;

    // Pick the more severe of two response codes
    function automatic logic [1:0] worse_resp(input logic [1:0] a, input logic [1:0] b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/lsplit_aw_fork.sv
// Address fork: accepts one upstream write address and issues a remapped
// request to each of the two narrow slaves. The two handshakes complete
// independently. A new upstream address is refused until the previous
// transaction's combined response has been taken (txn_done).
// Assumes an aligned INCR request no longer than half the length range.
module lsplit_aw_fork #(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 8,
    parameter int NSTRB  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] s_awaddr,
    input  logic [LEN_W-1:0]  s_awlen,
    input  logic              s_awvalid,
    output logic              s_awready,
    input  logic              txn_done,
    output logic [ADDR_W-1:0] m_awaddr [2],
    output logic [LEN_W-1:0]  m_awlen,
    output logic [1:0]        m_awvalid,
    input  logic [1:0]        m_awready
);
    logic              busy;
    logic [1:0]        pend;
    logic [ADDR_W-1:0] addr_q;
    logic [LEN_W-1:0]  len_q;

    assign s_awready = !busy;
    assign m_awvalid = pend;
    assign m_awlen   = len_q;

    // Per-side start address: the upper slave is offset by one narrow beat
    always_comb begin
        m_awaddr[0] = addr_q;
        m_awaddr[1] = addr_q + ADDR_W'(NSTRB);
    end

    // Capture a new request, retire each side's request on its handshake
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            pend   <= 2'b00;
            addr_q <= '0;
            len_q  <= '0;
        end else if (s_awvalid && !busy) begin
            busy   <= 1'b1;
            pend   <= 2'b11;
            addr_q <= s_awaddr;
            len_q  <= {s_awlen[LEN_W-2:0], 1'b1};
        end else begin
            pend <= pend & ~m_awready;
            if (txn_done) busy <= 1'b0;
        end
    end

    for (genvar g = 0; g < 2; g++) begin : g_chk
        a_r7_aw_hold: assert property (@(posedge clk) disable iff (!rst_n)
            m_awvalid[g] && !m_awready[g] |=> m_awvalid[g] && $stable(m_awaddr[g]) && $stable(m_awlen));
    end

endmodule

// File: rtl/lsplit_w_lane.sv
// One downstream data lane: for each held wide beat it sends a data beat
// carrying this lane's strobes, then a null beat with zero strobes. The last
// flag rides on the null beat of the final wide beat. 'drained' reports that
// both beats are gone (or leave this cycle); 'release_i' rearms the lane.
// Assumes the holding register stays full until release_i.
module lsplit_w_lane
    import axi_lsplit_pkg::*;
#(
    parameter int NB = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          beat_full,
    input  logic [NB-1:0] beat_strb,
    input  logic          beat_last,
    input  logic          release_i,
    input  logic          m_wready,
    output logic          m_wvalid,
    output logic [NB-1:0] m_wstrb,
    output logic          m_wlast,
    output logic          drained
);
    beat_phase_e phase;

    assign m_wvalid = beat_full && (phase != PH_DONE);
    assign m_wstrb  = (phase == PH_DATA) ? beat_strb : '0;
    assign m_wlast  = (phase == PH_NULL) && beat_last;
    assign drained  = (phase == PH_DONE) || ((phase == PH_NULL) && m_wvalid && m_wready);

    // Step data -> null -> done on each accepted beat; rearm on release
    always_ff @(posedge clk) begin
        if (!rst_n || release_i) begin
            phase <= PH_DATA;
        end else if (m_wvalid && m_wready) begin
            case (phase)
                PH_DATA: phase <= PH_NULL;
                PH_NULL: phase <= PH_DONE;
                default: phase <= PH_DONE;
            endcase
        end
    end

    a_r4_null_after_data: assert property (@(posedge clk) disable iff (!rst_n)
        m_wvalid && m_wready && (phase == PH_DATA) |=> m_wvalid && (m_wstrb == '0));
    a_r6_w_hold: assert property (@(posedge clk) disable iff (!rst_n)
        m_wvalid && !m_wready |=> m_wvalid && $stable(m_wstrb) && $stable(m_wlast));

endmodule

// File: rtl/lsplit_b_join.sv
// Response join: collects one response from each slave, then offers the
// more severe code upstream and holds it until accepted. txn_done pulses
// on the upstream handshake.
// Assumes each slave returns exactly one response per transaction.
module lsplit_b_join
    import axi_lsplit_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] m_bvalid,
    input  logic [1:0] m_bresp [2],
    output logic [1:0] m_bready,
    output logic       s_bvalid,
    output logic [1:0] s_bresp,
    input  logic       s_bready,
    output logic       txn_done
);
    logic [1:0] got;
    logic [1:0] resp_q [2];

    assign m_bready = ~got;
    assign s_bvalid = &got;
    assign s_bresp  = worse_resp(resp_q[0], resp_q[1]);
    assign txn_done = s_bvalid && s_bready;

    // Record each side's response once, clear all on upstream handshake
    always_ff @(posedge clk) begin
        if (!rst_n || txn_done) begin
            got       <= 2'b00;
            resp_q[0] <= 2'b00;
            resp_q[1] <= 2'b00;
        end else begin
            for (int i = 0; i < 2; i++) begin
                if (m_bvalid[i] && !got[i]) begin
                    got[i]    <= 1'b1;
                    resp_q[i] <= m_bresp[i];
                end
            end
        end
    end

    a_r9_b_hold: assert property (@(posedge clk) disable iff (!rst_n)
        s_bvalid && !s_bready |=> s_bvalid && $stable(s_bresp));
    a_r9_b_drop: assert property (@(posedge clk) disable iff (!rst_n)
        s_bvalid && s_bready |=> !s_bvalid);

endmodule

// File: rtl/axi_wr_lane_split.sv
// AXI write lane splitter: forwards each write from a wide master to two
// slaves of half the width, striping byte lanes. Each slave gets a burst of
// twice the length at half the size, with data beats interleaved with
// zero-strobe beats, so each burst stays legal. The two responses are merged.
// Assumes INCR bursts of full-width beats from a width-aligned start address,
// at most 2^(LEN_W-1) beats, and one transaction in flight.
module axi_wr_lane_split
    import axi_lsplit_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int NARROW_W = 128,
    parameter int LEN_W    = 8,
    localparam int WIDE_W  = 2 * NARROW_W,
    localparam int NSTRB   = NARROW_W / 8,
    localparam int WSTRB_W = 2 * NSTRB,
    localparam int NSIZE   = $clog2(NSTRB),
    localparam int WSIZE   = NSIZE + 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   s_awaddr,
    input  logic [LEN_W-1:0]    s_awlen,
    input  logic [2:0]          s_awsize,
    input  logic [1:0]          s_awburst,
    input  logic                s_awvalid,
    output logic                s_awready,
    input  logic [WIDE_W-1:0]   s_wdata,
    input  logic [WSTRB_W-1:0]  s_wstrb,
    input  logic                s_wlast,
    input  logic                s_wvalid,
    output logic                s_wready,
    output logic [1:0]          s_bresp,
    output logic                s_bvalid,
    input  logic                s_bready,
    output logic [ADDR_W-1:0]   lo_awaddr,
    output logic [LEN_W-1:0]    lo_awlen,
    output logic [2:0]          lo_awsize,
    output logic [1:0]          lo_awburst,
    output logic                lo_awvalid,
    input  logic                lo_awready,
    output logic [NARROW_W-1:0] lo_wdata,
    output logic [NSTRB-1:0]    lo_wstrb,
    output logic                lo_wlast,
    output logic                lo_wvalid,
    input  logic                lo_wready,
    input  logic [1:0]          lo_bresp,
    input  logic                lo_bvalid,
    output logic                lo_bready,
    output logic [ADDR_W-1:0]   hi_awaddr,
    output logic [LEN_W-1:0]    hi_awlen,
    output logic [2:0]          hi_awsize,
    output logic [1:0]          hi_awburst,
    output logic                hi_awvalid,
    input  logic                hi_awready,
    output logic [NARROW_W-1:0] hi_wdata,
    output logic [NSTRB-1:0]    hi_wstrb,
    output logic                hi_wlast,
    output logic                hi_wvalid,
    input  logic                hi_wready,
    input  logic [1:0]          hi_bresp,
    input  logic                hi_bvalid,
    output logic                hi_bready
);
    logic              txn_done;
    logic [ADDR_W-1:0] aw_addr [2];
    logic [LEN_W-1:0]  aw_len;
    logic [1:0]        aw_valid;
    logic [1:0]        b_resp_in [2];
    logic [1:0]        b_ready;

    logic                full;
    logic [WIDE_W-1:0]   data_q;
    logic [WSTRB_W-1:0]  strb_q;
    logic                last_q;
    logic                release_beat;
    logic [1:0]          w_ready;
    logic [1:0]          w_valid;
    logic [1:0]          w_last;
    logic [1:0]          drained;
    logic [NSTRB-1:0]    w_strb [2];

    // ---------------- address path ----------------
    lsplit_aw_fork #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .NSTRB(NSTRB)) u_aw (
        .clk       (clk),
        .rst_n     (rst_n),
        .s_awaddr  (s_awaddr),
        .s_awlen   (s_awlen),
        .s_awvalid (s_awvalid),
        .s_awready (s_awready),
        .txn_done  (txn_done),
        .m_awaddr  (aw_addr),
        .m_awlen   (aw_len),
        .m_awvalid (aw_valid),
        .m_awready ({hi_awready, lo_awready})
    );

    assign lo_awaddr  = aw_addr[0];
    assign hi_awaddr  = aw_addr[1];
    assign lo_awlen   = aw_len;
    assign hi_awlen   = aw_len;
    assign lo_awsize  = 3'(NSIZE);
    assign hi_awsize  = 3'(NSIZE);
    assign lo_awburst = BURST_INCR;
    assign hi_awburst = BURST_INCR;
    assign lo_awvalid = aw_valid[0];
    assign hi_awvalid = aw_valid[1];

    // ---------------- data path ----------------
    assign s_wready     = !full;
    assign release_beat = full && (&drained);
    assign w_ready      = {hi_wready, lo_wready};

    // Hold one wide beat until both lanes have sent both of their beats
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full   <= 1'b0;
            data_q <= '0;
            strb_q <= '0;
            last_q <= 1'b0;
        end else if (s_wvalid && !full) begin
            full   <= 1'b1;
            data_q <= s_wdata;
            strb_q <= s_wstrb;
            last_q <= s_wlast;
        end else if (release_beat) begin
            full <= 1'b0;
        end
    end

    for (genvar g = 0; g < 2; g++) begin : g_lane
        lsplit_w_lane #(.NB(NSTRB)) u_lane (
            .clk       (clk),
            .rst_n     (rst_n),
            .beat_full (full),
            .beat_strb (strb_q[g*NSTRB +: NSTRB]),
            .beat_last (last_q),
            .release_i (release_beat),
            .m_wready  (w_ready[g]),
            .m_wvalid  (w_valid[g]),
            .m_wstrb   (w_strb[g]),
            .m_wlast   (w_last[g]),
            .drained   (drained[g])
        );
    end

    assign lo_wdata  = data_q[NARROW_W-1:0];
    assign hi_wdata  = data_q[WIDE_W-1:NARROW_W];
    assign lo_wstrb  = w_strb[0];
    assign hi_wstrb  = w_strb[1];
    assign lo_wlast  = w_last[0];
    assign hi_wlast  = w_last[1];
    assign lo_wvalid = w_valid[0];
    assign hi_wvalid = w_valid[1];

    // ---------------- response path ----------------
    assign b_resp_in[0] = lo_bresp;
    assign b_resp_in[1] = hi_bresp;

    lsplit_b_join u_b (
        .clk      (clk),
        .rst_n    (rst_n),
        .m_bvalid ({hi_bvalid, lo_bvalid}),
        .m_bresp  (b_resp_in),
        .m_bready (b_ready),
        .s_bvalid (s_bvalid),
        .s_bresp  (s_bresp),
        .s_bready (s_bready),
        .txn_done (txn_done)
    );

    assign lo_bready = b_ready[0];
    assign hi_bready = b_ready[1];

    // ---------------- assertions ----------------
    a_r3_request_in_scope: assert property (@(posedge clk) disable iff (!rst_n)
        s_awvalid |-> (s_awsize == 3'(WSIZE)) && (s_awburst == BURST_INCR)
                      && (s_awaddr[WSIZE-1:0] == '0) && !s_awlen[LEN_W-1]);
    a_r6_wready_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_wvalid || hi_wvalid) |-> !s_wready);
    a_r8_aw_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        s_bvalid |-> !s_awready);
    a_r6_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
        full && !release_beat |=> $stable(lo_wdata) && $stable(hi_wdata));

endmodule

// File: tb/test_axi_wr_lane_split.sv
// Directed bench: a master task per scenario, two slave models with
// byte-addressed memories, and a reference memory built from master writes.
module test_axi_wr_lane_split;
    localparam int AW = 32;

    logic clk = 1'b0;
    always #5 clk = ~clk;
    logic rst_n;

    logic [AW-1:0]  s_awaddr;
    logic [7:0]     s_awlen;
    logic [2:0]     s_awsize;
    logic [1:0]     s_awburst;
    logic           s_awvalid, s_awready;
    logic [255:0]   s_wdata;
    logic [31:0]    s_wstrb;
    logic           s_wlast, s_wvalid, s_wready;
    logic [1:0]     s_bresp;
    logic           s_bvalid, s_bready;

    logic [AW-1:0]  d_awaddr [2];
    logic [7:0]     d_awlen [2];
    logic [2:0]     d_awsize [2];
    logic [1:0]     d_awburst [2];
    logic [1:0]     d_awvalid, d_wlast, d_wvalid, d_bready;
    logic [127:0]   d_wdata [2];
    logic [15:0]    d_wstrb [2];
    logic [1:0]     sl_awready, sl_wready, sl_bvalid;
    logic [1:0]     sl_bresp [2];

    axi_wr_lane_split i_axi_wr_lane_split (
        .clk(clk), .rst_n(rst_n),
        .s_awaddr(s_awaddr), .s_awlen(s_awlen), .s_awsize(s_awsize), .s_awburst(s_awburst),
        .s_awvalid(s_awvalid), .s_awready(s_awready),
        .s_wdata(s_wdata), .s_wstrb(s_wstrb), .s_wlast(s_wlast), .s_wvalid(s_wvalid), .s_wready(s_wready),
        .s_bresp(s_bresp), .s_bvalid(s_bvalid), .s_bready(s_bready),
        .lo_awaddr(d_awaddr[0]), .lo_awlen(d_awlen[0]), .lo_awsize(d_awsize[0]), .lo_awburst(d_awburst[0]),
        .lo_awvalid(d_awvalid[0]), .lo_awready(sl_awready[0]),
        .lo_wdata(d_wdata[0]), .lo_wstrb(d_wstrb[0]), .lo_wlast(d_wlast[0]), .lo_wvalid(d_wvalid[0]),
        .lo_wready(sl_wready[0]), .lo_bresp(sl_bresp[0]), .lo_bvalid(sl_bvalid[0]), .lo_bready(d_bready[0]),
        .hi_awaddr(d_awaddr[1]), .hi_awlen(d_awlen[1]), .hi_awsize(d_awsize[1]), .hi_awburst(d_awburst[1]),
        .hi_awvalid(d_awvalid[1]), .hi_awready(sl_awready[1]),
        .hi_wdata(d_wdata[1]), .hi_wstrb(d_wstrb[1]), .hi_wlast(d_wlast[1]), .hi_wvalid(d_wvalid[1]),
        .hi_wready(sl_wready[1]), .hi_bresp(sl_bresp[1]), .hi_bvalid(sl_bvalid[1]), .hi_bready(d_bready[1])
    );

    int n_checks = 0;
    int n_fail   = 0;

    task automatic chk(input string tag, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // ---------------- slave models ----------------
    int            bp_mode;
    logic [1:0]    resp_cfg [2];
    logic [AW-1:0] exp_addr;
    int            exp_len;
    int            cyc;
    bit            aw_have [2];
    bit            b_pend [2];
    bit            b_fire [2];
    int            b_wait [2];
    logic [AW-1:0] sb_base [2];
    int            sb_len [2];
    int            sb_beat [2];
    int            tot_beats [2];
    logic [7:0]    smem0 [int unsigned];
    logic [7:0]    smem1 [int unsigned];
    logic [7:0]    ref_mem [int unsigned];
    bit            in_txn;
    int            aw_open_cnt;

    function automatic bit rdy(input int s, input int kind);
        if (bp_mode == 0) return 1'b1;
        return ((cyc + 2*s + kind) % (3 + s)) != 0;
    endfunction

    // Slave behaviour: decide readies, log beats that fire at the next rising edge
    always @(negedge clk) begin
        cyc++;
        if (in_txn && s_awready) aw_open_cnt++;
        if (!rst_n) begin
            sl_awready = '0; sl_wready = '0; sl_bvalid = '0;
            for (int s = 0; s < 2; s++) begin
                aw_have[s] = 0; b_pend[s] = 0; b_fire[s] = 0; b_wait[s] = 0;
                sl_bresp[s] = 2'b00; tot_beats[s] = 0; sb_beat[s] = 0;
            end
        end else begin
            for (int s = 0; s < 2; s++) begin
                sl_awready[s] = !aw_have[s] && !b_pend[s] && !sl_bvalid[s] && rdy(s, 0);
                if (d_awvalid[s] && sl_awready[s]) begin
                    aw_have[s] = 1; sb_base[s] = d_awaddr[s]; sb_len[s] = int'(d_awlen[s]); sb_beat[s] = 0;
                    chk($sformatf("R2 start address side %0d", s), d_awaddr[s], exp_addr + 32'(16*s));
                    chk($sformatf("R3 length side %0d", s), d_awlen[s], 2*exp_len + 1);
                    chk($sformatf("R3 size side %0d", s), d_awsize[s], 4);
                    chk($sformatf("R3 burst side %0d", s), d_awburst[s], 1);
                end
                sl_wready[s] = aw_have[s] && rdy(s, 1);
                if (d_wvalid[s] && sl_wready[s]) begin
                    for (int i = 0; i < 16; i++) begin
                        if (d_wstrb[s][i]) begin
                            if (s == 0) smem0[sb_base[s] + 32'(16*sb_beat[s] + i)] = d_wdata[s][8*i +: 8];
                            else        smem1[sb_base[s] + 32'(16*sb_beat[s] + i)] = d_wdata[s][8*i +: 8];
                        end
                    end
                    if (sb_beat[s] % 2 == 1)
                        chk($sformatf("R4 null strobe side %0d beat %0d", s, sb_beat[s]), d_wstrb[s], 0);
                    chk($sformatf("R5 last side %0d beat %0d", s, sb_beat[s]), d_wlast[s], (sb_beat[s] == sb_len[s]) ? 1 : 0);
                    tot_beats[s]++;
                    if (d_wlast[s] || sb_beat[s] == sb_len[s]) begin
                        aw_have[s] = 0; b_pend[s] = 1; b_wait[s] = 2 + 3*s;
                    end
                    sb_beat[s]++;
                end
                if (b_fire[s]) begin
                    sl_bvalid[s] = 0; b_fire[s] = 0;
                end else if (b_pend[s]) begin
                    if (b_wait[s] > 0) b_wait[s]--;
                    else begin sl_bvalid[s] = 1; sl_bresp[s] = resp_cfg[s]; b_pend[s] = 0; end
                end
                if (sl_bvalid[s] && d_bready[s]) b_fire[s] = 1;
            end
        end
    end

    // ---------------- master helpers ----------------
    function automatic logic [7:0] byte_val(input logic [AW-1:0] a, input int seed);
        return a[7:0] ^ (a[15:8] * 8'd3) ^ 8'(seed);
    endfunction

    function automatic logic [31:0] strb_pat(input int mode, input int k);
        if (mode == 0) return 32'hFFFF_FFFF;
        case (k % 3)
            0:       return 32'h0000_FFFF;
            1:       return 32'hA5A5_0000;
            default: return 32'h1234_8001;
        endcase
    endfunction

    task automatic step();
        @(negedge clk); #1;
    endtask

    task automatic run_burst(input string name, input logic [AW-1:0] addr, input int len,
                             input int smode, input int seed, input int bp,
                             input logic [1:0] r0, input logic [1:0] r1);
        int t0 [2];
        int waited;
        logic [1:0] first_resp;
        logic [1:0] exp_resp;
        int mism;
        smem0.delete(); smem1.delete(); ref_mem.delete();
        bp_mode = bp; resp_cfg[0] = r0; resp_cfg[1] = r1;
        exp_addr = addr; exp_len = len; aw_open_cnt = 0;
        t0[0] = tot_beats[0]; t0[1] = tot_beats[1];
        // address
        s_awaddr = addr; s_awlen = 8'(len); s_awsize = 3'd5; s_awburst = 2'b01; s_awvalid = 1;
        while (!s_awready) step();
        step();
        s_awvalid = 0; in_txn = 1;
        // data
        for (int k = 0; k <= len; k++) begin
            logic [31:0] st;
            st = strb_pat(smode, k);
            for (int i = 0; i < 32; i++) begin
                logic [AW-1:0] a;
                a = addr + 32'(32*k + i);
                s_wdata[8*i +: 8] = byte_val(a, seed);
                if (st[i]) ref_mem[a] = byte_val(a, seed);
            end
            s_wstrb = st; s_wlast = (k == len); s_wvalid = 1;
            while (!s_wready) step();
            if (k > 0) begin
                chk($sformatf("R6 %s lower drained before beat %0d", name, k), tot_beats[0] - t0[0], 2*k);
                chk($sformatf("R6 %s upper drained before beat %0d", name, k), tot_beats[1] - t0[1], 2*k);
            end
            step();
        end
        s_wvalid = 0; s_wlast = 0;
        // response, held off for two cycles
        s_bready = 0; waited = 0;
        while (!s_bvalid && waited < 2000) begin step(); waited++; end
        first_resp = s_bresp;
        step(); step();
        chk($sformatf("R9 %s response held", name), {s_bvalid, s_bresp}, {1'b1, first_resp});
        exp_resp = (r0 > r1) ? r0 : r1;
        chk($sformatf("R9 %s merged code", name), s_bresp, exp_resp);
        s_bready = 1; in_txn = 0;
        step();
        s_bready = 0;
        chk($sformatf("R9 %s response dropped", name), s_bvalid, 0);
        chk($sformatf("R8 %s address ready low while open", name), aw_open_cnt, 0);
        chk($sformatf("R3 %s lower beat count", name), tot_beats[0] - t0[0], 2*(len+1));
        chk($sformatf("R3 %s upper beat count", name), tot_beats[1] - t0[1], 2*(len+1));
        // memory comparison
        mism = 0;
        foreach (ref_mem[a]) begin
            if (a[4] == 1'b0) begin
                if (!smem0.exists(a) || smem0[a] != ref_mem[a]) mism++;
            end else begin
                if (!smem1.exists(a) || smem1[a] != ref_mem[a]) mism++;
            end
        end
        chk($sformatf("R10 %s byte mismatches", name), mism, 0);
        chk($sformatf("R10 %s byte count", name), smem0.size() + smem1.size(), ref_mem.size());
        mism = 0;
        foreach (smem0[a]) if (a[4]) mism++;
        foreach (smem1[a]) if (!a[4]) mism++;
        chk($sformatf("R1 %s lane halves", name), mism, 0);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        chk("R11 awready after reset", s_awready, 1);
        chk("R11 wready after reset", s_wready, 1);
        chk("R11 downstream valids after reset", {d_awvalid, d_wvalid}, 0);
        chk("R11 bvalid after reset", s_bvalid, 0);
    endtask

    task automatic t_example();
        run_burst("four beats at zero", 32'h0, 3, 0, 1, 0, 2'b00, 2'b00);
        chk("R1 lower holds 0x00", smem0.exists(32'h00), 1);
        chk("R1 lower skips 0x10", smem0.exists(32'h10), 0);
        chk("R1 upper holds 0x70", smem1.exists(32'h70), 1);
        chk("R10 lower byte total", smem0.size(), 64);
        chk("R10 upper byte total", smem1.size(), 64);
    endtask

    task automatic t_single();
        run_burst("single beat", 32'h1000, 0, 1, 7, 1, 2'b10, 2'b00);
    endtask

    task automatic t_long_stall();
        run_burst("sixteen beats stalled", 32'h2040, 15, 1, 3, 1, 2'b00, 2'b11);
    endtask

    task automatic t_errors();
        run_burst("eight beats two errors", 32'h0300_0000, 7, 0, 9, 0, 2'b11, 2'b10);
        run_burst("two beats exokay", 32'h0000_4020, 1, 1, 5, 1, 2'b00, 2'b01);
    endtask

    initial begin
        rst_n = 0; s_awvalid = 0; s_wvalid = 0; s_wlast = 0; s_bready = 0; in_txn = 0;
        s_awaddr = '0; s_awlen = '0; s_awsize = 3'd5; s_awburst = 2'b01; s_wdata = '0; s_wstrb = '0;
        bp_mode = 0; resp_cfg[0] = 0; resp_cfg[1] = 0; exp_addr = '0; exp_len = 0; cyc = 0;
        repeat (4) @(negedge clk);
        rst_n = 1;
        step();
        t_reset();
        t_example();
        t_single();
        t_long_stall();
        t_errors();
        repeat (5) step();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule